// File: doc/BRIEF.md
# Transmit K2 Line Alarm Inserter

This block sits in the transmit overhead path of a single outgoing frame stream. Once per frame it produces the two protection-signalling bytes. The first byte and the top five bits of the second byte are copied from configuration values. The three low bits of the second byte carry the line alarm code, chosen by a fixed priority. Forced line AIS comes first. Forced line RDI comes second. Automatic RDI, raised by receive-side defects, comes third. The configured low bits are used when none of these apply. Whenever RDI is sent, it stays on for a minimum number of frames (20 by default) after the last frame that requested it.

The block also produces a per-byte fill qualifier. A later stage uses it to replace every byte that is not section overhead with all-ones before scrambling. The qualifier is raised for a whole frame in two cases: AIS is forced, or loss of signal or loss of frame was seen on the receive side. The receive-side case can be disabled.

Frame timing comes from two inputs. A one-cycle strobe marks the first byte of each frame, and a flag marks section-overhead byte positions. All alarm decisions are taken at the strobe, so the outputs never change in the middle of a frame.

Top module: `k2_alarm_tx`

## Requirements
- R1: At each frame strobe, `tx_k1` loads `cfg_k1` and `tx_k2[7:3]` loads `cfg_k2[7:3]`. The new values are visible from the cycle after the strobe.
- R2: If `force_ais` is high at the strobe, `tx_k2[2:0]` becomes 3'b111 for that frame, whatever the other controls are.
- R3: If `force_rdi` is high at the strobe, the strobe reloads the hold. `tx_k2[2:0]` is 3'b110 in that frame and in the following 19 frames unless `force_ais` is high.
- R4: When `auto_rdi_off` is low, a defect (`rx_los`, `rx_lof` or `rx_ais_l`) counts for a strobe if it is high in the strobe cycle or in any cycle since the previous strobe. Such a defect reloads the same 20-frame hold as R3.
- R5: If neither AIS nor RDI applies at the strobe, `tx_k2[2:0]` takes `cfg_k2[2:0]`. While `auto_rdi_off` is high, defects do not raise RDI.
- R6: Automatic RDI is the default. With `auto_rdi_off` tied low, a defect after reset raises RDI with no other setup.
- R7: If `force_ais` was high at the strobe, `ais_fill` is high on every byte of that frame where `soh_pos` is low. It is never high on a byte where `soh_pos` is high.
- R8: If LOS or LOF counts at the strobe (as in R4) and `dstream_ais_off` is low, `ais_fill` behaves as in R7 for that frame. An `rx_ais_l` defect alone does not raise `ais_fill`.
- R9: `tx_k1` and `tx_k2` change only in the cycle after a strobe. Changing the configuration in the middle of a frame has no effect until the next strobe.
- R10: Reset clears `tx_k1`, `tx_k2`, `ais_fill`, the RDI hold and the defect memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe on the first byte of a frame |
| soh_pos | input | 1 | Current byte is a section-overhead position |
| cfg_k1 | input | 8 | Configured first protection byte |
| cfg_k2 | input | 8 | Configured second protection byte |
| force_ais | input | 1 | Manual line AIS insertion |
| force_rdi | input | 1 | Manual line RDI insertion |
| auto_rdi_off | input | 1 | Disables defect-driven RDI (low by default) |
| dstream_ais_off | input | 1 | Disables the all-ones fill caused by LOS/LOF |
| rx_los | input | 1 | Receive loss of signal |
| rx_lof | input | 1 | Receive loss of frame |
| rx_ais_l | input | 1 | Receive line AIS detected |
| tx_k1 | output | 8 | Transmitted first protection byte |
| tx_k2 | output | 8 | Transmitted second protection byte |
| ais_fill | output | 1 | Replace the current byte with all-ones |

## Verification
The hardest case to reach is the boundary where the RDI hold runs out. Reaching it requires a trigger, then exactly 19 idle frames, then a check that the 21st frame carries the configured bits again. The stimulus table therefore holds each trigger with a run of more than twenty quiet frames behind it. A second hard case is a defect that lasts a single mid-frame cycle, which only the defect memory can catch. A directed test pulses LOS on one byte inside a frame and checks that the next frame shows both RDI and the fill.

// File: rtl/k2a_pkg.sv
package k2a_pkg;

  localparam int KW     = 8;
  localparam int CODE_W = 3;

  localparam logic [CODE_W-1:0] CODE_AIS = 3'b111;
  localparam logic [CODE_W-1:0] CODE_RDI = 3'b110;

  typedef enum logic [1:0] {
    SRC_CFG = 2'd0,
    SRC_RDI = 2'd1,
    SRC_AIS = 2'd2
  } k2_src_e;

  typedef struct packed {
    logic los;
    logic lof;
    logic ais_l;
  } defect_t;

  localparam int NUM_DEF = $bits(defect_t);

  // Priority: forced AIS, then any live RDI, then configured bits.
  function automatic k2_src_e pick_src(input logic ais_req, input logic rdi_req);
    if (ais_req)      return SRC_AIS;
    else if (rdi_req) return SRC_RDI;
    else              return SRC_CFG;
  endfunction

  function automatic logic [CODE_W-1:0] code_of(input k2_src_e src,
                                                input logic [CODE_W-1:0] cfg_bits);
    case (src)
      SRC_AIS: return CODE_AIS;
      SRC_RDI: return CODE_RDI;
      default: return cfg_bits;
    endcase
  endfunction

  // Defects that ask for RDI when automatic mode is on.
  function automatic logic rdi_cause(input defect_t d, input logic auto_on);
    return auto_on && (d.los || d.lof || d.ais_l);
  endfunction

  // Defects that ask for downstream all-ones fill.
  function automatic logic fill_cause(input defect_t d, input logic fill_on);
    return fill_on && (d.los || d.lof);
  endfunction

endpackage

// File: rtl/k2a_defect_sticky.sv
module k2a_defect_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_start,
  input  logic [N-1:0] def_in,
  output logic [N-1:0] def_seen
);

  logic [N-1:0] held_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)           held_q[i] <= 1'b0;
      else if (frame_start) held_q[i] <= 1'b0;
      else if (def_in[i])   held_q[i] <= 1'b1;
    end
    // Seen at this boundary: earlier in the frame, or right now.
    assign def_seen[i] = held_q[i] | def_in[i];
  end

endmodule

// File: rtl/k2a_rdi_hold.sv
module k2a_rdi_hold #(
  parameter int HOLD_FRAMES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic trig,
  output logic rdi_on,
  output logic hold_live
);

  localparam int CNT_W = $clog2(HOLD_FRAMES + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_FRAMES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (frame_start) begin
      if (trig)            cnt_q <= RELOAD;
      else if (hold_live)  cnt_q <= cnt_q - 1'b1;
    end
  end

  assign hold_live = (cnt_q != '0);
  assign rdi_on    = trig | hold_live;

endmodule

// File: rtl/k2a_kbyte_reg.sv
module k2a_kbyte_reg
  import k2a_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic [KW-1:0] k1_next,
  input  logic [KW-1:0] k2_next,
  input  logic          fill_next,
  output logic [KW-1:0] k1_q,
  output logic [KW-1:0] k2_q,
  output logic          fill_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      k1_q   <= '0;
      k2_q   <= '0;
      fill_q <= 1'b0;
    end else if (frame_start) begin
      k1_q   <= k1_next;
      k2_q   <= k2_next;
      fill_q <= fill_next;
    end
  end

endmodule

// File: rtl/k2_alarm_tx.sv
module k2_alarm_tx
  import k2a_pkg::*;
#(
  parameter int HOLD_FRAMES = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          soh_pos,
  input  logic [KW-1:0] cfg_k1,
  input  logic [KW-1:0] cfg_k2,
  input  logic          force_ais,
  input  logic          force_rdi,
  input  logic          auto_rdi_off,
  input  logic          dstream_ais_off,
  input  logic          rx_los,
  input  logic          rx_lof,
  input  logic          rx_ais_l,
  output logic [KW-1:0] tx_k1,
  output logic [KW-1:0] tx_k2,
  output logic          ais_fill
);

  defect_t    def_now;
  defect_t    def_seen;
  logic       bnd_trigger;
  logic       rdi_on;
  logic       hold_live;
  logic       fill_frame_q;
  k2_src_e    src_sel;
  logic [KW-1:0] k2_next;
  logic       fill_next;

  assign def_now = '{los: rx_los, lof: rx_lof, ais_l: rx_ais_l};

  k2a_defect_sticky #(.N(NUM_DEF)) u_sticky (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .def_in      (def_now),
    .def_seen    (def_seen)
  );

  assign bnd_trigger = force_rdi | rdi_cause(def_seen, !auto_rdi_off);

  k2a_rdi_hold #(.HOLD_FRAMES(HOLD_FRAMES)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .trig        (bnd_trigger),
    .rdi_on      (rdi_on),
    .hold_live   (hold_live)
  );

  assign src_sel   = pick_src(force_ais, rdi_on);
  assign k2_next   = {cfg_k2[KW-1:CODE_W], code_of(src_sel, cfg_k2[CODE_W-1:0])};
  assign fill_next = force_ais | fill_cause(def_seen, !dstream_ais_off);

  k2a_kbyte_reg u_kreg (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .k1_next     (cfg_k1),
    .k2_next     (k2_next),
    .fill_next   (fill_next),
    .k1_q        (tx_k1),
    .k2_q        (tx_k2),
    .fill_q      (fill_frame_q)
  );

  assign ais_fill = fill_frame_q & ~soh_pos;

endmodule

// File: rtl/k2a_checker.sv
module k2a_checker
  import k2a_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          frame_start,
  input logic          soh_pos,
  input logic [KW-1:0] cfg_k1,
  input logic [KW-1:0] cfg_k2,
  input logic          force_ais,
  input logic          force_rdi,
  input logic          auto_rdi_off,
  input logic          dstream_ais_off,
  input logic          rx_los,
  input logic          rx_lof,
  input logic          rx_ais_l,
  input logic [KW-1:0] tx_k1,
  input logic [KW-1:0] tx_k2,
  input logic          ais_fill,
  input logic          bnd_trigger,
  input logic          hold_live
);

  p_k1_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (tx_k1 == $past(cfg_k1)) && (tx_k2[7:3] == $past(cfg_k2[7:3])));

  p_ais_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && force_ais |=> tx_k2[2:0] == CODE_AIS);

  p_hold_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !force_ais && (force_rdi || hold_live) |=> tx_k2[2:0] == CODE_RDI);

  p_auto_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !force_ais && !auto_rdi_off && (rx_los || rx_lof || rx_ais_l)
      |=> tx_k2[2:0] == CODE_RDI);

  p_cfg_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !force_ais && !bnd_trigger && !hold_live
      |=> tx_k2[2:0] == $past(cfg_k2[2:0]));

  p_ais_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && force_ais |=> (soh_pos || ais_fill));

  p_fill_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !force_ais && dstream_ais_off |=> !ais_fill);

  p_kstable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(tx_k1) && $stable(tx_k2));

endmodule

bind k2_alarm_tx k2a_checker u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .frame_start     (frame_start),
  .soh_pos         (soh_pos),
  .cfg_k1          (cfg_k1),
  .cfg_k2          (cfg_k2),
  .force_ais       (force_ais),
  .force_rdi       (force_rdi),
  .auto_rdi_off    (auto_rdi_off),
  .dstream_ais_off (dstream_ais_off),
  .rx_los          (rx_los),
  .rx_lof          (rx_lof),
  .rx_ais_l        (rx_ais_l),
  .tx_k1           (tx_k1),
  .tx_k2           (tx_k2),
  .ais_fill        (ais_fill),
  .bnd_trigger     (bnd_trigger),
  .hold_live       (hold_live)
);

// File: tb/tb_k2_alarm_tx.sv
`timescale 1ns/1ps
module tb_k2_alarm_tx;

  localparam int FLEN  = 8;
  localparam int SOHN  = 3;
  localparam int HOLD  = 20;
  localparam int NVEC  = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0, soh_pos = 1'b0;
  logic [7:0] cfg_k1 = '0, cfg_k2 = '0;
  logic force_ais = 1'b0, force_rdi = 1'b0, auto_rdi_off = 1'b0, dstream_ais_off = 1'b0;
  logic rx_los = 1'b0, rx_lof = 1'b0, rx_ais_l = 1'b0;
  logic [7:0] tx_k1, tx_k2;
  logic ais_fill;

  int n_chk = 0;
  int n_fail = 0;
  int m_cnt = 0;
  logic p_los = 1'b0, p_lof = 1'b0, p_ais = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  k2_alarm_tx dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .soh_pos(soh_pos),
    .cfg_k1(cfg_k1), .cfg_k2(cfg_k2), .force_ais(force_ais), .force_rdi(force_rdi),
    .auto_rdi_off(auto_rdi_off), .dstream_ais_off(dstream_ais_off),
    .rx_los(rx_los), .rx_lof(rx_lof), .rx_ais_l(rx_ais_l),
    .tx_k1(tx_k1), .tx_k2(tx_k2), .ais_fill(ais_fill)
  );

  // {frames[6], fa, fr, ao, dso, los, lof, aisl, k1[8], k2[8]}
  localparam logic [28:0] VEC [NVEC] = '{
    {6'd2,  7'b0000000, 8'hA5, 8'h3C},
    {6'd1,  7'b1000000, 8'hA5, 8'h3C},
    {6'd2,  7'b0000000, 8'h17, 8'hF1},
    {6'd1,  7'b0100000, 8'h17, 8'hF1},
    {6'd25, 7'b0000000, 8'h17, 8'hF1},
    {6'd1,  7'b0000100, 8'h42, 8'hF1},
    {6'd23, 7'b0000000, 8'h42, 8'hF1},
    {6'd2,  7'b0001010, 8'h42, 8'hF1},
    {6'd23, 7'b0000000, 8'h42, 8'hF1},
    {6'd2,  7'b0010001, 8'h42, 8'hF1},
    {6'd2,  7'b0000001, 8'h42, 8'hF1},
    {6'd3,  7'b1100000, 8'h99, 8'h5A},
    {6'd23, 7'b0000000, 8'h99, 8'h5A}
  };

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One frame; pulse=1 drives LOS only on byte 4 instead of the whole frame.
  task automatic do_frame(input logic [28:0] v, input bit pulse, input string tag);
    logic [7:0] k2 = v[7:0];
    logic [7:0] k1 = v[15:8];
    logic aisl = v[16], lof = v[17], los = v[18];
    logic dso = v[19], ao = v[20], fr = v[21], fa = v[22];
    logic s_los, s_lof, s_ais, trig, ef;
    logic [2:0] ec;
    int fill_bad = 0;
    string lbl;
    s_los = (los & !pulse) | p_los;
    s_lof = lof | p_lof;
    s_ais = aisl | p_ais;
    trig  = fr | (!ao & (s_los | s_lof | s_ais));
    if (fa) ec = 3'b111;
    else if (trig || m_cnt != 0) ec = 3'b110;
    else ec = k2[2:0];
    m_cnt = trig ? HOLD - 1 : (m_cnt != 0 ? m_cnt - 1 : 0);
    ef = fa | (!dso & (s_los | s_lof));
    if (fa) lbl = "R2";
    else if (ec == 3'b110 && trig && tag != "") lbl = tag;
    else if (ec == 3'b110) lbl = "R3/R4";
    else lbl = "R5";
    for (int b = 0; b < FLEN; b++) begin
      @(negedge clk);
      frame_start = (b == 0);
      soh_pos = (b < SOHN);
      force_ais = fa; force_rdi = fr; auto_rdi_off = ao; dstream_ais_off = dso;
      rx_lof = lof; rx_ais_l = aisl;
      rx_los = pulse ? (b == 4) : los;
      if (b == 0) begin cfg_k1 = k1; cfg_k2 = k2; end
      if (b == 3) begin cfg_k1 = ~k1; cfg_k2 = ~k2; end
      #1;
      if (b == 1) begin
        chk(tx_k1 == k1, "R1 k1", tx_k1, k1);
        chk(tx_k2[7:3] == k2[7:3], "R1 k2 upper", {3'b0, tx_k2[7:3]}, {3'b0, k2[7:3]});
        chk(tx_k2[2:0] == ec, lbl, {5'b0, tx_k2[2:0]}, {5'b0, ec});
      end
      if (b > 0 && ais_fill !== ((b >= SOHN) & ef)) fill_bad++;
      if (b == FLEN - 1)
        chk(tx_k1 == k1 && tx_k2 == {k2[7:3], ec}, "R9 mid-frame hold", tx_k1, k1);
    end
    chk(fill_bad == 0, fa ? "R7 fill" : "R8 fill", 8'(fill_bad), 8'd0);
    p_los = los | pulse; p_lof = lof; p_ais = aisl;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; frame_start = 1'b0; soh_pos = 1'b0;
    force_ais = 0; force_rdi = 0; auto_rdi_off = 0; dstream_ais_off = 0;
    rx_los = 0; rx_lof = 0; rx_ais_l = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_cnt = 0; p_los = 0; p_lof = 0; p_ais = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    // R10: reset state
    chk(tx_k1 == 8'h00, "R10 k1 reset", tx_k1, 8'h00);
    chk(tx_k2 == 8'h00, "R10 k2 reset", tx_k2, 8'h00);
    chk(ais_fill == 1'b0, "R10 fill reset", {7'b0, ais_fill}, 8'h00);

    // R6: auto RDI active straight out of reset
    do_frame({6'd1, 7'b0000100, 8'h11, 8'h23}, 1'b0, "R6");
    do_frame({6'd1, 7'b0000000, 8'h11, 8'h23}, 1'b0, "");

    // table walk
    for (int i = 0; i < NVEC; i++)
      for (int f = 0; f < int'(VEC[i][28:23]); f++)
        do_frame(VEC[i], 1'b0, "");

    // R4/R8: single mid-frame LOS pulse caught at the next boundary
    do_frame({6'd1, 7'b0000000, 8'h33, 8'h44}, 1'b1, "R4 pulse");
    do_frame({6'd1, 7'b0000000, 8'h33, 8'h44}, 1'b0, "R4 pulse");

    // R10: reset during an active hold clears it
    do_frame({6'd1, 7'b0100000, 8'h55, 8'h65}, 1'b0, "R3");
    do_reset();
    #1;
    chk(tx_k2 == 8'h00, "R10 k2 after mid-hold reset", tx_k2, 8'h00);
    do_frame({6'd1, 7'b0000000, 8'h55, 8'h65}, 1'b0, "");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule